// File: doc/BRIEF.md
# Dual-Mode Column Data Serializer

This block takes the display bytes of one LCD row from an external static display memory and shifts them out as serial streams for the column drivers. A one-cycle start request gives it a base address and a length in bytes. It then reads the row one byte at a time, turns each byte into shift-clock periods, and drives the result on a set of data pins, each paired with a shift clock.

Two configuration pins set the output arrangement. The scan pin chooses between one screen and two screens (an upper and a lower half). In dual scan, every byte index is read twice. The upper-half copy is read with address bit 15 low and the lower-half copy with bit 15 high; the lower 15 bits are the same for both. The split pin chooses between two output styles. In odd/even split, each period carries one odd-column bit and one even-column bit. In plain serial, each period carries one column bit on the shared line.

In single scan the two lower-area pins are not needed for display data. They then become active-low chip selects that decode the first two 2 KB banks of display memory.

Top module: `column_serializer`

## Requirements
- R1: While reset is low or halt is high, and in the cycle after either is removed, busy, mem_rd and hscp are low. In single scan, lod_cs0 and lscp_cs1 are also high at that point.
- R2: ed and hod keep their values through any cycle in which reset is low or halt is high. Reset and halt clear only the sequencing state.
- R3: A start pulse seen while idle with a nonzero row_len sets busy high from the next cycle and latches row_addr, row_len and both mode pins. A start with row_len zero is ignored. Each read raises mem_rd for exactly one cycle. Single scan reads (row_addr+i) mod 2^16 for i = 0 to row_len-1. Dual scan reads {0,(row_addr+i)[14:0]} and then {1,(row_addr+i)[14:0]}.
- R4: The byte used for a read is mem_rdata as sampled at the end of the cycle in which mem_rd is high.
- R5: In plain serial, ed carries the byte's bits 7 down to 0, one bit per shift period, and hod does not change.
- R6: In odd/even split, period j (j = 0 to 3) puts bit 7-2j on the odd line and bit 6-2j on ed. The odd line is hod for upper-half bytes and lod_cs0 for lower-half bytes.
- R7: A shift period is one cycle with its clock low followed by one cycle with it high. Data changes only on the edge that takes the clock low, so data is stable while the clock is high.
- R8: Upper-half bytes pulse hscp only, and lower-half bytes pulse the lower clock on lscp_cs1 only. The two clocks are never high together. In single scan there are no lower-half bytes.
- R9: In single scan, lod_cs0 is low exactly when mem_rd is high and mem_addr is in 0000h–07FFh. lscp_cs1 is low exactly when mem_rd is high and mem_addr is in 0800h–0FFFh.
- R10: While busy, start, row_addr, row_len and both mode pins have no effect on the row in progress.
- R11: Each fetched byte gives 4 shift pulses in split mode and 8 in plain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt | input | 1 | High stops and clears the sequencer |
| start | input | 1 | Begins a row when idle |
| row_addr | input | 16 | First byte address of the row |
| row_len | input | 8 | Row length in bytes |
| dual_scan | input | 1 | 1 = two screens, 0 = one screen |
| odd_even | input | 1 | 1 = odd/even split, 0 = plain serial |
| busy | output | 1 | Row in progress |
| mem_rd | output | 1 | Display memory read strobe |
| mem_addr | output | 16 | Display memory address |
| mem_rdata | input | 8 | Display memory read data |
| ed | output | 1 | Even (or all) column data, shared by both halves |
| hod | output | 1 | Upper-half odd column data |
| hscp | output | 1 | Upper-half shift clock |
| lod_cs0 | output | 1 | Lower-half odd data (dual) / bank 0 chip select, active low (single) |
| lscp_cs1 | output | 1 | Lower-half shift clock (dual) / bank 1 chip select, active low (single) |

## Verification
The bench walks rows across the 64 KB boundary and the 32 KB half boundary in dual scan. A design that carried bit 15 into the lower-half address, or did not force it, would send the wrong half to a screen. Rows that cross 07FFh/0800h catch a chip-select decoder that is off by one bank or that asserts outside a read. Halt and reset are applied in the middle of a shift. Start pulses and mode-pin flips are applied while busy. A design that cleared the data lines, or re-sampled the pins during a row, would give a stream that differs from the expected image.

// File: rtl/colser_pkg.sv
// Shared types for the column serializer.
package colser_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FETCH,
        ST_LO,
        ST_HI
    } seq_st_t;
endpackage

// File: rtl/colser_seq.sv
// Row sequencer.
// Purpose: it walks a row of bytes, issues a single-cycle read for each byte
// (two reads per index in dual scan), and times the shift periods: one low
// cycle and one high cycle of the shift clock for the half being served.
// Assumptions: memory read data is valid in the same cycle as mem_rd. The mode
// pins are static while idle and are latched when a row starts. A shift
// period is two clock cycles.
module colser_seq #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              start,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic [LEN_W-1:0]  row_len,
    input  logic              dual_pin,
    input  logic              split_pin,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              load,
    output logic              step,
    output logic              hclk,
    output logic              lclk,
    output logic              slot_lo,
    output logic              dual_q,
    output logic              split_q,
    output logic              clr
);
    import colser_pkg::*;

    localparam int CNT_W     = $clog2(DATA_W);
    localparam int PER_SPLIT = DATA_W / 2;
    localparam int PER_PLAIN = DATA_W;

    seq_st_t           st;
    logic [LEN_W-1:0]  idx;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_cnt;
    logic              done;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] next_addr;

    // Sequencer clear: reset or halt.
    assign clr = !rst_n || halt;

    // Last period index of a byte for the latched output style.
    assign last_cnt = split_q ? CNT_W'(PER_SPLIT - 1) : CNT_W'(PER_PLAIN - 1);

    // Address of the current index, with the half forced into the top bit in dual scan.
    always_comb begin
        sum = base_q + ADDR_W'(idx);
        if (dual_q) begin
            next_addr = {slot_lo, sum[ADDR_W-2:0]};
        end else begin
            next_addr = sum;
        end
    end

    // Strobes for the shifter, gated so that nothing moves during a clear.
    assign load = (st == ST_FETCH) && !clr;
    assign step = (st == ST_LO) && !clr;

    // Main sequencing state.
    always_ff @(posedge clk) begin
        if (clr) begin
            st       <= ST_IDLE;
            busy     <= 1'b0;
            mem_rd   <= 1'b0;
            mem_addr <= '0;
            hclk     <= 1'b0;
            lclk     <= 1'b0;
            slot_lo  <= 1'b0;
            cnt      <= '0;
            idx      <= '0;
            len_q    <= '0;
            base_q   <= '0;
            done     <= 1'b0;
            dual_q   <= dual_pin;
            split_q  <= split_pin;
        end else begin
            case (st)
                ST_IDLE: begin
                    dual_q  <= dual_pin;
                    split_q <= split_pin;
                    if (start && (row_len != '0)) begin
                        base_q  <= row_addr;
                        len_q   <= row_len;
                        idx     <= '0;
                        slot_lo <= 1'b0;
                        done    <= 1'b0;
                        busy    <= 1'b1;
                        st      <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    hclk <= 1'b0;
                    lclk <= 1'b0;
                    if (done) begin
                        busy <= 1'b0;
                        st   <= ST_IDLE;
                    end else begin
                        mem_rd   <= 1'b1;
                        mem_addr <= next_addr;
                        st       <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    mem_rd <= 1'b0;
                    cnt    <= '0;
                    st     <= ST_LO;
                end
                ST_LO: begin
                    hclk <= 1'b0;
                    lclk <= 1'b0;
                    st   <= ST_HI;
                end
                ST_HI: begin
                    if (slot_lo) begin
                        lclk <= 1'b1;
                    end else begin
                        hclk <= 1'b1;
                    end
                    if (cnt == last_cnt) begin
                        if (dual_q && !slot_lo) begin
                            slot_lo <= 1'b1;
                        end else begin
                            slot_lo <= 1'b0;
                            if (idx == len_q - LEN_W'(1)) begin
                                done <= 1'b1;
                            end else begin
                                idx <= idx + LEN_W'(1);
                            end
                        end
                        st <= ST_ISSUE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                        st  <= ST_LO;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/colser_shift.sv
// Byte shifter and data-line registers.
// Purpose: it loads a fetched byte and, on each step, sends the top bit (plain
// serial) or the top two bits (odd/even split) to the data lines, MSB first.
// Assumptions: load and step never come in the same cycle. The data lines
// have no reset, so they keep their last value through reset and halt.
module colser_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              load,
    input  logic              step,
    input  logic              split,
    input  logic              slot_lo,
    input  logic [DATA_W-1:0] rdata,
    output logic              ed_q,
    output logic              hod_q,
    output logic              lod_q
);
    logic [DATA_W-1:0] shreg;

    // Capture the fetched byte, then consume one or two bits per period.
    always_ff @(posedge clk) begin
        if (load) begin
            shreg <= rdata;
        end else if (step) begin
            if (split) begin
                shreg <= {shreg[DATA_W-3:0], 2'b00};
            end else begin
                shreg <= {shreg[DATA_W-2:0], 1'b0};
            end
        end
    end

    // Put the period's bits on the data lines; a line not written keeps its value.
    always_ff @(posedge clk) begin
        if (step) begin
            if (split) begin
                ed_q <= shreg[DATA_W-2];
                if (slot_lo) begin
                    lod_q <= shreg[DATA_W-1];
                end else begin
                    hod_q <= shreg[DATA_W-1];
                end
            end else begin
                ed_q <= shreg[DATA_W-1];
            end
        end
    end
endmodule

// File: rtl/colser_pins.sv
// Lower-half pin routing.
// Purpose: in dual scan it routes the lower-half odd data and the lower shift
// clock to the shared pins. In single scan the same pins carry active-low
// selects for the first two memory banks.
// Assumptions: a bank is 2^BANK_BITS bytes, and a select is active only while
// a read is in progress.
module colser_pins #(
    parameter int ADDR_W    = 16,
    parameter int BANK_BITS = 11
) (
    input  logic              dual_q,
    input  logic              lod_q,
    input  logic              lclk,
    input  logic              mem_rd,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              lod_cs0,
    output logic              lscp_cs1
);
    localparam int BANK_W = ADDR_W - BANK_BITS;

    logic [BANK_W-1:0] bank;
    logic              cs0_n;
    logic              cs1_n;

    // Bank decode of the current read address.
    always_comb begin
        bank  = mem_addr[ADDR_W-1:BANK_BITS];
        cs0_n = !(mem_rd && (bank == BANK_W'(0)));
        cs1_n = !(mem_rd && (bank == BANK_W'(1)));
    end

    // Pin function picked by the latched scan mode.
    assign lod_cs0  = dual_q ? lod_q : cs0_n;
    assign lscp_cs1 = dual_q ? lclk  : cs1_n;
endmodule

// File: rtl/column_serializer.sv
// Dual-mode column data serializer, top level.
// Purpose: it joins the row sequencer, the byte shifter and the lower-half
// pin routing.
// Assumptions: display memory answers within the read cycle. The mode pins
// take effect only between rows.
module column_serializer #(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 8,
    parameter int DATA_W    = 8,
    parameter int BANK_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              start,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic [LEN_W-1:0]  row_len,
    input  logic              dual_scan,
    input  logic              odd_even,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ed,
    output logic              hod,
    output logic              hscp,
    output logic              lod_cs0,
    output logic              lscp_cs1
);
    logic load;
    logic step;
    logic hclk;
    logic lclk;
    logic slot_lo;
    logic dual_q;
    logic split_q;
    logic clr;
    logic lod_q;

    colser_seq #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .start     (start),
        .row_addr  (row_addr),
        .row_len   (row_len),
        .dual_pin  (dual_scan),
        .split_pin (odd_even),
        .busy      (busy),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .load      (load),
        .step      (step),
        .hclk      (hclk),
        .lclk      (lclk),
        .slot_lo   (slot_lo),
        .dual_q    (dual_q),
        .split_q   (split_q),
        .clr       (clr)
    );

    colser_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk     (clk),
        .load    (load),
        .step    (step),
        .split   (split_q),
        .slot_lo (slot_lo),
        .rdata   (mem_rdata),
        .ed_q    (ed),
        .hod_q   (hod),
        .lod_q   (lod_q)
    );

    colser_pins #(
        .ADDR_W    (ADDR_W),
        .BANK_BITS (BANK_BITS)
    ) u_pins (
        .dual_q   (dual_q),
        .lod_q    (lod_q),
        .lclk     (lclk),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .lod_cs0  (lod_cs0),
        .lscp_cs1 (lscp_cs1)
    );

    // Upper shift clock straight from the sequencer.
    assign hscp = hclk;
endmodule

// File: rtl/colser_chk.sv
// Property checker for the column serializer, bound to the top level.
// Purpose: it watches the clocking, pin routing and hold behaviour over time.
// Assumptions: it is bound to column_serializer and sees its internal wires by name.
module colser_chk (
    input logic clk,
    input logic rst_n,
    input logic halt,
    input logic busy,
    input logic mem_rd,
    input logic hscp,
    input logic ed,
    input logic hod,
    input logic lod_cs0,
    input logic hclk,
    input logic lclk,
    input logic dual_q,
    input logic clr
);
    logic started = 1'b0;

    // Marks that one edge has passed, so $past has a value.
    always_ff @(posedge clk) started <= 1'b1;

    // R2
    data_hold_chk: assert property (@(posedge clk)
        started && $past(clr) |-> ($stable(ed) && $stable(hod)));

    // R7
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || halt)
        hscp |-> ($stable(ed) && $stable(hod)));

    // R8
    clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n || halt)
        !(hclk && lclk));

    // R8
    single_no_lclk_chk: assert property (@(posedge clk) disable iff (!rst_n || halt)
        !dual_q |-> !lclk);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || halt)
        !busy |-> (!mem_rd && !hclk && !lclk));

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || halt)
        mem_rd |=> !mem_rd);

    // R9
    cs_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n || halt)
        (!dual_q && !lod_cs0) |-> mem_rd);
endmodule

bind column_serializer colser_chk u_chk (.*);

// File: tb/column_serializer_tb.sv
`timescale 1ns/1ps
module column_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic        start = 1'b0;
    logic [15:0] row_addr = '0;
    logic [7:0]  row_len = '0;
    logic        dual_scan = 1'b0;
    logic        odd_even = 1'b0;
    logic        busy;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        ed;
    logic        hod;
    logic        hscp;
    logic        lod_cs0;
    logic        lscp_cs1;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    column_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .start     (start),
        .row_addr  (row_addr),
        .row_len   (row_len),
        .dual_scan (dual_scan),
        .odd_even  (odd_even),
        .busy      (busy),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .ed        (ed),
        .hod       (hod),
        .hscp      (hscp),
        .lod_cs0   (lod_cs0),
        .lscp_cs1  (lscp_cs1)
    );

    // Display memory image, computed from the address.
    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
    endfunction
    assign mem_rdata = pat(mem_addr);

    // Monitor state.
    bit          mon_on = 1'b0;
    bit          cur_dual = 1'b0;
    logic        hprev = 1'b0;
    logic        lprev = 1'b0;
    logic [1:0]  up_q[$];
    logic [1:0]  lo_q[$];
    logic [15:0] addr_q[$];
    int          cs_err = 0;
    int          cs_seen = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (hscp && !hprev) up_q.push_back({hod, ed});
            if (cur_dual && lscp_cs1 && !lprev) lo_q.push_back({lod_cs0, ed});
            if (mem_rd) addr_q.push_back(mem_addr);
            if (!cur_dual) begin
                cs_seen++;
                if (lod_cs0 !== !(mem_rd && mem_addr < 16'h0800)) cs_err++;
                if (lscp_cs1 !== !(mem_rd && mem_addr >= 16'h0800 && mem_addr < 16'h1000)) cs_err++;
            end
        end
        hprev = hscp;
        lprev = lscp_cs1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic launch(input logic [15:0] a, input logic [7:0] n,
                          input bit d, input bit s);
        dual_scan = d;
        odd_even = s;
        cur_dual = d;
        repeat (3) @(negedge clk);
        up_q.delete();
        lo_q.delete();
        addr_q.delete();
        cs_err = 0;
        cs_seen = 0;
        row_addr = a;
        row_len = n;
        mon_on = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        mon_on = 1'b0;
    endtask

    task automatic verify(input logic [15:0] a, input logic [7:0] n,
                          input bit d, input bit s, input logic hod0, input string tag);
        logic [15:0] ea[$];
        logic [1:0]  eu[$];
        logic [1:0]  el[$];
        int per;
        int bad;
        per = s ? 4 : 8;
        for (int i = 0; i < n; i++) begin
            logic [15:0] sa = a + 16'(i);
            if (d) begin
                ea.push_back({1'b0, sa[14:0]});
                ea.push_back({1'b1, sa[14:0]});
            end else begin
                ea.push_back(sa);
            end
        end
        for (int k = 0; k < ea.size(); k++) begin
            logic [7:0] b = pat(ea[k]);
            for (int j = 0; j < per; j++) begin
                logic [1:0] e;
                if (s) e = {b[7-2*j], b[6-2*j]};
                else   e = {1'b0, b[7-j]};
                if (d && ea[k][15]) el.push_back(e);
                else                eu.push_back(e);
            end
        end
        // R3: read address sequence
        bad = 0;
        if (addr_q.size() != ea.size()) bad = 1;
        else for (int k = 0; k < ea.size(); k++) if (addr_q[k] !== ea[k]) bad = 1;
        check(bad == 0, "R3", {tag, " read addresses"}, addr_q.size(), ea.size());
        // R11: pulse counts per half
        check(up_q.size() == eu.size(), "R11", {tag, " upper pulse count"}, up_q.size(), eu.size());
        check(lo_q.size() == el.size(), "R8", {tag, " lower pulse count"}, lo_q.size(), el.size());
        // R4 R5 R6: stream contents
        bad = 0;
        if (up_q.size() == eu.size())
            for (int k = 0; k < eu.size(); k++)
                if ((s ? up_q[k] : {1'b0, up_q[k][0]}) !== eu[k]) bad++;
        check(bad == 0, s ? "R6" : "R5", {tag, " upper stream R4"}, bad, 0);
        bad = 0;
        if (lo_q.size() == el.size())
            for (int k = 0; k < el.size(); k++)
                if ((s ? lo_q[k] : {1'b0, lo_q[k][0]}) !== el[k]) bad++;
        check(bad == 0, s ? "R6" : "R5", {tag, " lower stream"}, bad, 0);
        if (!s) check(hod === hod0, "R5", {tag, " hod unchanged"}, hod, hod0);
    endtask

    task automatic t_reset_state();
        dual_scan = 1'b0;
        do_reset();
        // R1
        check(!busy && !mem_rd && !hscp, "R1", "busy/rd/clock after reset",
              {busy, mem_rd, hscp}, 0);
        check(lod_cs0 && lscp_cs1, "R1", "selects high after reset",
              {lod_cs0, lscp_cs1}, 3);
    endtask

    task automatic t_row(input logic [15:0] a, input logic [7:0] n,
                         input bit d, input bit s, input string tag);
        logic h0;
        h0 = hod;
        launch(a, n, d, s);
        wait_idle();
        verify(a, n, d, s, h0, tag);
    endtask

    task automatic t_chip_select();
        launch(16'h07FE, 8'd4, 1'b0, 1'b0);
        wait_idle();
        // R9
        check(cs_err == 0 && cs_seen > 0, "R9", "bank selects across 0800h", cs_err, 0);
        launch(16'h2000, 8'd2, 1'b0, 1'b1);
        wait_idle();
        check(cs_err == 0, "R9", "bank selects idle outside banks", cs_err, 0);
    endtask

    task automatic t_busy_ignore();
        logic h0;
        h0 = hod;
        launch(16'h1234, 8'd3, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        // R10: disturb inputs while busy
        row_addr = 16'h4000;
        row_len = 8'd9;
        dual_scan = 1'b0;
        odd_even = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        verify(16'h1234, 8'd3, 1'b1, 1'b0, h0, "R10 busy-ignore");
    endtask

    task automatic t_zero_len();
        launch(16'h0100, 8'd0, 1'b0, 1'b0);
        @(negedge clk);
        mon_on = 1'b0;
        // R3
        check(!busy, "R3", "zero length start ignored", busy, 0);
    endtask

    task automatic t_hold();
        logic e0;
        logic h0;
        launch(16'h0345, 8'd3, 1'b0, 1'b1);
        repeat (17) @(negedge clk);
        e0 = ed;
        h0 = hod;
        halt = 1'b1;
        repeat (4) @(negedge clk);
        // R2
        check(ed === e0 && hod === h0, "R2", "lines held in halt", {ed, hod}, {e0, h0});
        // R1
        check(!busy && !hscp && !mem_rd, "R1", "quiet in halt", {busy, hscp, mem_rd}, 0);
        halt = 1'b0;
        @(negedge clk);
        mon_on = 1'b0;
        launch(16'h0A51, 8'd3, 1'b0, 1'b1);
        repeat (21) @(negedge clk);
        e0 = ed;
        h0 = hod;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(ed === e0 && hod === h0, "R2", "lines held in reset", {ed, hod}, {e0, h0});
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b0;
        check(!busy && !hscp, "R1", "quiet after reset", {busy, hscp}, 0);
    endtask

    initial begin
        t_reset_state();
        t_row(16'h0040, 8'd3, 1'b0, 1'b0, "R5 R7 single plain");
        t_row(16'h1F3C, 8'd4, 1'b0, 1'b1, "R6 single split");
        t_row(16'hFFFE, 8'd3, 1'b0, 1'b0, "R3 single wrap");
        t_row(16'h0210, 8'd3, 1'b1, 1'b0, "R8 dual plain");
        t_row(16'h7FFF, 8'd2, 1'b1, 1'b1, "R8 dual split half-wrap");
        t_chip_select();
        t_busy_ignore();
        t_zero_len();
        t_hold();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule